// File: doc/BRIEF.md
# Byte-Wide PROM Configuration Fetcher

This block runs the self-clocked master mode that loads configuration data from an external byte-wide PROM. It produces the configuration clock from a divided oscillator tick, drives an 18-bit PROM address, captures one byte per address, and shifts that byte out one bit per configuration clock, most significant bit first, to a frame parser downstream. The address sequence is ascending from zero or descending from the top of the address space. The mode pins select the direction. A latched rate input makes the configuration clock eight times faster.

A controller starts and stops loading. When the parser reports a frame error, the block stops delivering bits, but the configuration clock and the address keep running. The three mode pins are also decoded for the other configuration modes. For those modes the block only raises flags and takes no other action.

Top module: `prom_byte_loader`

## Requirements
- R1: While rstN is low, and in the cycle after it rises, promAddr is 0, cfgClk is 0, bitValid is 0 and serialBit is 1.
- R2: modeCode is decoded combinationally. modeParallel is 1 only for codes 3'b100 and 3'b110. cclkIsOutput is 1 for codes 3'b000, 3'b100, 3'b101 and 3'b110. modeReserved is 1 only for codes 3'b001 and 3'b010.
- R3: A start while modeCode is 3'b100 loads promAddr with 0x00000. Each following byte uses the next address up. promAddr changes only in the same cycle as a start load, or in the cycle where cfgClk rises and shifts out the eighth bit of the current byte.
- R4: A start while modeCode is 3'b110 loads promAddr with 0x3FFFF. Each following byte uses the next address down.
- R5: Every rising edge of cfgClk during normal loading gives exactly one bitValid pulse of one clk cycle. serialBit carries the bits of the byte read at promAddr, most significant bit first, eight bits per address.
- R6: At the slow rate, cfgClk holds each level for 8 oscTick pulses, so a full period is 16 pulses.
- R7: One cycle with fastRate high sets the fast rate, which then persists until reset. At the fast rate a cfgClk period is 2 oscTick pulses, and it stays at 2 after fastRate returns low.
- R8: A stop pulse freezes cfgClk, promAddr and serialBit, and bitValid stays 0, until the next start. The address is not reset.
- R9: After a frameErr pulse, bitValid stays 0 and serialBit holds its value, while cfgClk keeps toggling and promAddr keeps stepping.
- R10: A start while modeParallel is 0 has no effect, and cfgClk does not toggle afterwards.
- R11: A start reloads the starting address, clears the frame-error suspension, and restarts the byte at its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCode | input | 3 | Mode pins, highest pin in bit 2 |
| oscTick | input | 1 | One-cycle enable pulse from the divided oscillator |
| fastRate | input | 1 | Rate-select request, latched when high |
| start | input | 1 | Start pulse: load the starting address and run |
| stop | input | 1 | Stop pulse: freeze the clock, the address and the data |
| frameErr | input | 1 | Frame error pulse from the parser |
| promData | input | 8 | Byte read from the PROM at promAddr |
| promAddr | output | 18 | PROM address |
| cfgClk | output | 1 | Generated configuration clock |
| serialBit | output | 1 | Serialized configuration bit |
| bitValid | output | 1 | One-cycle pulse when serialBit holds a new bit |
| modeParallel | output | 1 | Mode code selects one of the two master parallel modes |
| cclkIsOutput | output | 1 | Mode code drives the configuration clock as an output |
| modeReserved | output | 1 | Mode code is a reserved value |

## Verification
The hardest case to reach from the ports is a frame error part-way through a run. Loading must stop while cfgClk and promAddr keep moving, and a later start must resume cleanly at the first bit of the starting address. To get there, the stimulus runs several bytes in the fast rate and injects one frameErr pulse at a point set by random tick density. It then counts cfgClk rises, bitValid pulses and address changes over a long window, and restarts and checks the reloaded address and the fresh bytes. The rate change is applied in the middle of a descending run, so it lands part-way through a clock phase. The bench then confirms that the period settles at two ticks and stays there after the request is dropped.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [2:0] {
    MODE_SER_MASTER  = 3'b000,
    MODE_RSV_LOW     = 3'b001,
    MODE_RSV_MID     = 3'b010,
    MODE_BUS_SYNC    = 3'b011,
    MODE_PAR_UP      = 3'b100,
    MODE_BUS_ASYNC   = 3'b101,
    MODE_PAR_DOWN    = 3'b110,
    MODE_SER_SLAVE   = 3'b111
  } modeSel_t;

  typedef struct packed {
    logic loadAddr;
    logic dirDown;
    logic bitStep;
    logic byteLoad;
    logic addrStep;
    logic emit;
  } ldStrobe_t;

endpackage

// File: rtl/cfgld_mode_dec.sv
module cfgld_mode_dec
  import cfgld_pkg::*;
(
  input  logic [2:0] modeCode,
  output logic       parMode,
  output logic       downDir,
  output logic       cclkOut,
  output logic       reserved
);

  modeSel_t modeSel;

  always_comb begin
    modeSel  = modeSel_t'(modeCode);
    parMode  = 1'b0;
    downDir  = 1'b0;
    cclkOut  = 1'b0;
    reserved = 1'b0;
    unique case (modeSel)
      MODE_SER_MASTER: cclkOut = 1'b1;
      MODE_PAR_UP: begin
        parMode = 1'b1;
        cclkOut = 1'b1;
      end
      MODE_PAR_DOWN: begin
        parMode = 1'b1;
        downDir = 1'b1;
        cclkOut = 1'b1;
      end
      MODE_BUS_ASYNC: cclkOut = 1'b1;
      MODE_BUS_SYNC, MODE_SER_SLAVE: cclkOut = 1'b0;
      MODE_RSV_LOW, MODE_RSV_MID: reserved = 1'b1;
      default: reserved = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int SLOW_DIV    = 8,
  parameter int FAST_FACTOR = 8,
  parameter int BYTE_W      = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      oscTick,
  input  logic      fastRate,
  input  logic      start,
  input  logic      stop,
  input  logic      frameErr,
  input  logic      parMode,
  input  logic      downDir,
  output ldStrobe_t strb,
  output logic      cfgClk
);

  localparam int FAST_DIV_RAW = SLOW_DIV / FAST_FACTOR;
  localparam int FAST_DIV     = (FAST_DIV_RAW < 1) ? 1 : FAST_DIV_RAW;
  localparam int DIV_W        = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int BIT_W        = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [DIV_W-1:0] SLOW_END = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_END = DIV_W'(FAST_DIV - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfEnd;
  logic [BIT_W-1:0] bitIdx;
  logic running;
  logic suspended;
  logic fastLatched;
  logic dirLatched;
  logic startOk;
  logic advance;
  logic phaseEnd;
  logic riseNow;

  always_comb begin
    startOk  = start & parMode & ~stop;
    halfEnd  = fastLatched ? FAST_END : SLOW_END;
    advance  = running & ~stop & ~startOk & oscTick;
    phaseEnd = advance & (divCnt >= halfEnd);
    riseNow  = phaseEnd & ~cfgClk;

    strb.loadAddr = startOk;
    strb.dirDown  = startOk ? downDir : dirLatched;
    strb.bitStep  = riseNow;
    strb.byteLoad = riseNow & (bitIdx == '0);
    strb.addrStep = riseNow & (bitIdx == LAST_BIT);
    strb.emit     = riseNow & ~suspended & ~frameErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running     <= 1'b0;
      suspended   <= 1'b0;
      fastLatched <= 1'b0;
      dirLatched  <= 1'b0;
      divCnt      <= '0;
      bitIdx      <= '0;
      cfgClk      <= 1'b0;
    end else begin
      fastLatched <= fastLatched | fastRate;
      if (stop) begin
        running <= 1'b0;
      end else if (startOk) begin
        running    <= 1'b1;
        suspended  <= 1'b0;
        dirLatched <= downDir;
        divCnt     <= '0;
        bitIdx     <= '0;
        cfgClk     <= 1'b0;
      end else if (running) begin
        if (frameErr) suspended <= 1'b1;
        if (advance) begin
          if (phaseEnd) begin
            divCnt <= '0;
            cfgClk <= ~cfgClk;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        if (riseNow) begin
          bitIdx <= (bitIdx == LAST_BIT) ? '0 : bitIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfgld_dp.sv
module cfgld_dp
  import cfgld_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldStrobe_t         strb,
  input  logic [BYTE_W-1:0] promData,
  output logic [ADDR_W-1:0] promAddr,
  output logic              serialBit,
  output logic              bitValid
);

  localparam logic [ADDR_W-1:0] ADDR_LOW  = '0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = '1;

  logic [BYTE_W-1:0] shiftReg;
  logic              nextBit;

  always_comb begin
    nextBit = strb.byteLoad ? promData[BYTE_W-1] : shiftReg[BYTE_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      promAddr <= ADDR_LOW;
    end else if (strb.loadAddr) begin
      promAddr <= strb.dirDown ? ADDR_HIGH : ADDR_LOW;
    end else if (strb.addrStep) begin
      promAddr <= strb.dirDown ? promAddr - 1'b1 : promAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      serialBit <= 1'b1;
      bitValid  <= 1'b0;
    end else begin
      bitValid <= strb.emit;
      if (strb.byteLoad) begin
        shiftReg <= promData << 1;
      end else if (strb.bitStep) begin
        shiftReg <= shiftReg << 1;
      end
      if (strb.emit) serialBit <= nextBit;
    end
  end

endmodule

// File: rtl/prom_byte_loader.sv
module prom_byte_loader
  import cfgld_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int BYTE_W      = 8,
  parameter int SLOW_DIV    = 8,
  parameter int FAST_FACTOR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeCode,
  input  logic              oscTick,
  input  logic              fastRate,
  input  logic              start,
  input  logic              stop,
  input  logic              frameErr,
  input  logic [BYTE_W-1:0] promData,
  output logic [ADDR_W-1:0] promAddr,
  output logic              cfgClk,
  output logic              serialBit,
  output logic              bitValid,
  output logic              modeParallel,
  output logic              cclkIsOutput,
  output logic              modeReserved
);

  ldStrobe_t strb;
  logic      downDir;

  cfgld_mode_dec u_dec (
    .modeCode (modeCode),
    .parMode  (modeParallel),
    .downDir  (downDir),
    .cclkOut  (cclkIsOutput),
    .reserved (modeReserved)
  );

  cfgld_ctrl #(
    .SLOW_DIV    (SLOW_DIV),
    .FAST_FACTOR (FAST_FACTOR),
    .BYTE_W      (BYTE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .oscTick  (oscTick),
    .fastRate (fastRate),
    .start    (start),
    .stop     (stop),
    .frameErr (frameErr),
    .parMode  (modeParallel),
    .downDir  (downDir),
    .strb     (strb),
    .cfgClk   (cfgClk)
  );

  cfgld_dp #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .promData  (promData),
    .promAddr  (promAddr),
    .serialBit (serialBit),
    .bitValid  (bitValid)
  );

endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              stop,
  input logic              frameErr,
  input logic [ADDR_W-1:0] promAddr,
  input logic              cfgClk,
  input logic              serialBit,
  input logic              bitValid,
  input logic              modeParallel,
  input logic              cclkIsOutput,
  input logic              modeReserved
);

  // R2
  reserved_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeReserved |-> (!modeParallel && !cclkIsOutput));

  // R3
  addr_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (promAddr != $past(promAddr)) |-> ($rose(cfgClk) || $past(start)));

  // R5
  bit_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> $rose(cfgClk));

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stop) |-> ($stable(cfgClk) && $stable(promAddr) && $stable(serialBit) && !bitValid));

  // R9
  err_mute_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(frameErr) |-> (!bitValid && $stable(serialBit)));

endmodule

bind prom_byte_loader cfgld_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .stop         (stop),
  .frameErr     (frameErr),
  .promAddr     (promAddr),
  .cfgClk       (cfgClk),
  .serialBit    (serialBit),
  .bitValid     (bitValid),
  .modeParallel (modeParallel),
  .cclkIsOutput (cclkIsOutput),
  .modeReserved (modeReserved)
);

// File: tb/prom_byte_loader_tb.sv
`timescale 1ns/1ps
module prom_byte_loader_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  modeCode = 3'b000;
  logic        oscTick = 1'b0;
  logic        fastRate = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic        frameErr = 1'b0;
  logic [7:0]  promData;
  logic [17:0] promAddr;
  logic        cfgClk, serialBit, bitValid;
  logic        modeParallel, cclkIsOutput, modeReserved;

  int checkCnt = 0;
  int failCnt  = 0;
  int tickMod  = 2;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] promFn(input logic [17:0] a);
    promFn = a[7:0] ^ {a[13:10], a[17:14]} ^ 8'hA5 ^ {a[8], a[9], 6'b0};
  endfunction

  assign promData = promFn(promAddr);

  prom_byte_loader u_dut (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .oscTick(oscTick),
    .fastRate(fastRate), .start(start), .stop(stop), .frameErr(frameErr),
    .promData(promData), .promAddr(promAddr), .cfgClk(cfgClk),
    .serialBit(serialBit), .bitValid(bitValid), .modeParallel(modeParallel),
    .cclkIsOutput(cclkIsOutput), .modeReserved(modeReserved)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor state
  int          riseCnt = 0;
  int          validCnt = 0;
  int          byteCnt = 0;
  int          tickCnt = 0;
  int          lastPeriod = 0;
  int          bitCnt = 0;
  logic [7:0]  gotByte = '0;
  logic [17:0] capAddr = '0;
  logic [17:0] expAddr = '0;
  bit          expDown = 1'b0;
  logic        prevClk = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (cfgClk && !prevClk) begin
        riseCnt++;
        lastPeriod = tickCnt;
        tickCnt = 0;
      end
      if (oscTick) tickCnt++;
      if (bitValid) begin
        validCnt++;
        if (bitCnt == 0) capAddr = promAddr;
        gotByte = {gotByte[6:0], serialBit};
        bitCnt++;
        if (bitCnt == 8) begin
          chk(gotByte == promFn(capAddr), "R5 byte", int'(gotByte), int'(promFn(capAddr)));
          if (expDown) chk(capAddr == expAddr, "R4 addr", int'(capAddr), int'(expAddr));
          else         chk(capAddr == expAddr, "R3 addr", int'(capAddr), int'(expAddr));
          expAddr = expDown ? expAddr - 18'd1 : expAddr + 18'd1;
          bitCnt = 0;
          byteCnt++;
        end
      end
    end
    prevClk = cfgClk;
  end

  initial begin
    void'($urandom(32'd4242));
    forever begin
      @(posedge clk);
      #1 oscTick = (($urandom % tickMod) == 0);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  task automatic doStart(input logic [2:0] code, input bit down, input logic [17:0] first);
    modeCode = code;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    bitCnt = 0;
    expDown = down;
    expAddr = first;
  endtask

  task automatic waitBytes(input int n);
    int target = byteCnt + n;
    for (int g = 0; g < 40000 && byteCnt < target; g++) @(posedge clk);
    #1;
    chk(byteCnt >= target, "R5 byte count", byteCnt, target);
  endtask

  task automatic waitRises(input int n);
    int target = riseCnt + n;
    for (int g = 0; g < 20000 && riseCnt < target; g++) @(posedge clk);
    #1;
  endtask

  initial begin
    int r0, v0;
    logic [17:0] a0;
    logic c0;
    bit expPar, expOut, expRsv;

    // R1: reset state
    cycles(3);
    chk(promAddr == 0, "R1 addr", promAddr, 0);
    chk(cfgClk == 0, "R1 cfgClk", cfgClk, 0);
    chk(bitValid == 0, "R1 bitValid", bitValid, 0);
    chk(serialBit == 1, "R1 serialBit", serialBit, 1);
    @(posedge clk); #1 rstN = 1'b1;
    cycles(1);
    chk(promAddr == 0 && cfgClk == 0, "R1 after release", {promAddr, cfgClk}, 0);

    // R2: decode all mode codes
    for (int c = 0; c < 8; c++) begin
      modeCode = 3'(c);
      #1;
      expPar = (c == 4) || (c == 6);
      expOut = (c == 0) || (c == 4) || (c == 5) || (c == 6);
      expRsv = (c == 1) || (c == 2);
      chk({modeParallel, cclkIsOutput, modeReserved} == {expPar, expOut, expRsv},
          "R2 flags", {modeParallel, cclkIsOutput, modeReserved}, {expPar, expOut, expRsv});
    end

    // R10: start in non-parallel modes ignored
    tickMod = 1;
    doStart(3'b111, 1'b0, 18'd0);
    doStart(3'b011, 1'b0, 18'd0);
    r0 = riseCnt;
    cycles(200);
    chk(riseCnt == r0 && validCnt == 0, "R10 no clock", riseCnt, r0);

    // R3: ascending from zero, slow rate
    tickMod = 1 + ($urandom % 3);
    doStart(3'b100, 1'b0, 18'd0);
    chk(promAddr == 18'd0, "R3 start addr", promAddr, 0);
    waitBytes(3 + ($urandom % 3));
    // R6: slow period
    chk(lastPeriod == 16, "R6 slow period", lastPeriod, 16);

    // R4: descending from top
    tickMod = 1 + ($urandom % 3);
    doStart(3'b110, 1'b1, 18'h3FFFF);
    chk(promAddr == 18'h3FFFF, "R4 start addr", promAddr, 18'h3FFFF);
    waitBytes(3);

    // R7: rate raised mid-run, stays after request drops
    cycles(5 + ($urandom % 20));
    pulse(fastRate);
    waitRises(4);
    chk(lastPeriod == 2, "R7 fast period", lastPeriod, 2);
    waitBytes(4);
    chk(lastPeriod == 2, "R7 fast sticky", lastPeriod, 2);

    // R8: stop freezes clock, address, data
    cycles($urandom % 7);
    pulse(stop);
    a0 = promAddr; c0 = cfgClk; v0 = validCnt; r0 = riseCnt;
    cycles(300);
    chk(promAddr == a0, "R8 addr held", promAddr, a0);
    chk(cfgClk == c0 && riseCnt == r0, "R8 clock held", riseCnt, r0);
    chk(validCnt == v0, "R8 no bits", validCnt, v0);

    // R11: restart reloads ascending start
    doStart(3'b100, 1'b0, 18'd0);
    chk(promAddr == 18'd0, "R11 reload addr", promAddr, 0);
    waitBytes(3);

    // R9: frame error mutes data, clock and address continue
    cycles($urandom % 9);
    pulse(frameErr);
    v0 = validCnt; r0 = riseCnt; a0 = promAddr;
    cycles(600);
    chk(validCnt == v0, "R9 no bits", validCnt, v0);
    chk(riseCnt > r0 + 20, "R9 clock runs", riseCnt, r0 + 20);
    chk(promAddr != a0, "R9 addr steps", promAddr, a0);

    // R11: start clears the suspension
    doStart(3'b110, 1'b1, 18'h3FFFF);
    chk(promAddr == 18'h3FFFF, "R11 reload down", promAddr, 18'h3FFFF);
    v0 = validCnt;
    waitBytes(2);
    chk(validCnt >= v0 + 16, "R11 bits resume", validCnt, v0 + 16);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule